// File: doc/BRIEF.md
# Received Pattern Capture Register

This block keeps a running window of the last 32 bits seen on a serial receive line and, on request, freezes a copy of it into a register that the host reads one byte at a time. A snapshot is requested by a rising edge on either of two sources: a control bit written by software, or a dedicated input pin. The two sources are edge-detected on their own and their rising edges are combined, so whichever rises first triggers the capture.

What gets frozen depends on the receiver's lock state at the moment of the trigger. While the receiver is unlocked, the snapshot is the raw line history, which is what the host needs to find out what pattern is arriving. While it is locked, the snapshot is taken from the 32-bit window of the local reference generator that the receiver is tracking. Line errors therefore never reach the captured value once lock is held. Because the reference window carries no start-of-pattern marker, the captured value is any rotation of the locked pattern.

The synchronizer that decides lock and the reference generator both sit outside this block.

Top module: `rx_pattern_capture`

## Requirements
- R1: While `rst` is high on a clock edge, the snapshot and the internal line history are cleared to zero, so after reset `snap` reads 0 and every byte lane reads 0.
- R2: On every clock edge with `rst` low, the line history shifts left by one position and takes `rx_bit` into bit 0. After 32 bits are sent first-to-last, the first bit sent sits in bit 31.
- R3: On a trigger edge while `in_lock` is low, `snap` takes the history as it stood before that edge: the 32 bits taken in on the 32 preceding edges. The bit present on the trigger edge itself is not included.
- R4: On a trigger edge while `in_lock` is high, `snap` takes `ref_window` as sampled on that edge. The value of `rx_bit`, including any line errors, has no effect on the captured value.
- R5: A low-to-high change of `cap_pin` (high on this edge, low on the previous one) is a trigger edge, and it behaves exactly like one from `cap_ctl`.
- R6: When neither source rises, `snap` keeps its value. A source that stays high does not trigger again.
- R7: When both sources rise on the same edge, or one rises while the other stays high, exactly one capture takes place on that edge.
- R8: `rd_byte` returns a byte of `snap` selected by `byte_sel` without delay: 0 gives bits 31:24, 1 gives bits 23:16, 2 gives bits 15:8 and 3 gives bits 7:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one received bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Received serial data bit |
| in_lock | input | 1 | High while the receiver is synchronized |
| ref_window | input | 32 | Current 32-bit window of the locked reference pattern |
| cap_ctl | input | 1 | Software capture request bit (rising edge triggers) |
| cap_pin | input | 1 | Hardware capture request pin (rising edge triggers) |
| byte_sel | input | 2 | Byte lane select for host reads |
| snap | output | 32 | Captured pattern |
| rd_byte | output | 8 | Selected byte of the captured pattern |

## Verification
A wrong history register only becomes visible through the next unlocked capture. The snapshot then shows a shifted, stale or corrupted window in the cycle right after the trigger edge. A faulty edge detector shows up as a snapshot that changes while a source is held high, or that does not change when a source rises, on the very next cycle. A wrong lock-based source choice shows up as line bits in place of the reference window on the cycle after a locked trigger. Comparing the snapshot and the selected byte against a reference model on every cycle catches each of these one cycle after the edge that causes it.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

    localparam int PAT_W   = 32;
    localparam int BYTE_W  = 8;
    localparam int NUM_SRC = 2;

    typedef enum logic {
        SRC_LINE = 1'b0,
        SRC_REF  = 1'b1
    } cap_src_e;

    typedef struct packed {
        logic     fire;
        cap_src_e src;
    } cap_req_t;

    function automatic cap_src_e pick_source(input logic locked);
        return locked ? SRC_REF : SRC_LINE;
    endfunction

endpackage

// File: rtl/pcap_history.sv
module pcap_history #(
    parameter int W = pcap_pkg::PAT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rx_bit,
    output logic [W-1:0] hist_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else begin
            hist_q <= {hist_q[W-2:0], rx_bit};
        end
    end

endmodule

// File: rtl/pcap_trigger.sv
module pcap_trigger #(
    parameter int N = pcap_pkg::NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src_lvl,
    output logic         fire
);

    logic [N-1:0] prev_q;
    logic [N-1:0] rise;

    for (genvar g = 0; g < N; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q[g] <= 1'b0;
            end else begin
                prev_q[g] <= src_lvl[g];
            end
        end
        assign rise[g] = src_lvl[g] & ~prev_q[g];
    end

    assign fire = |rise;

endmodule

// File: rtl/pcap_snap.sv
module pcap_snap #(
    parameter int W = pcap_pkg::PAT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  pcap_pkg::cap_req_t req,
    input  logic [W-1:0]       line_win,
    input  logic [W-1:0]       ref_win,
    output logic [W-1:0]       snap_q
);

    import pcap_pkg::*;

    logic [W-1:0] chosen;

    always_comb begin
        unique case (req.src)
            SRC_REF:  chosen = ref_win;
            default:  chosen = line_win;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
        end else if (req.fire) begin
            snap_q <= chosen;
        end
    end

endmodule

// File: rtl/rx_pattern_capture.sv
module rx_pattern_capture #(
    parameter int PAT_W  = pcap_pkg::PAT_W,
    parameter int BYTE_W = pcap_pkg::BYTE_W,
    parameter int SEL_W  = $clog2(PAT_W / BYTE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_bit,
    input  logic              in_lock,
    input  logic [PAT_W-1:0]  ref_window,
    input  logic              cap_ctl,
    input  logic              cap_pin,
    input  logic [SEL_W-1:0]  byte_sel,
    output logic [PAT_W-1:0]  snap,
    output logic [BYTE_W-1:0] rd_byte
);

    import pcap_pkg::*;

    localparam int NUM_LANES = PAT_W / BYTE_W;

    logic [PAT_W-1:0]  hist_q;
    logic              fire;
    cap_req_t          req;
    logic [BYTE_W-1:0] lane [NUM_LANES];

    pcap_history #(.W(PAT_W)) i_history (
        .clk    (clk),
        .rst    (rst),
        .rx_bit (rx_bit),
        .hist_q (hist_q)
    );

    pcap_trigger #(.N(NUM_SRC)) i_trigger (
        .clk     (clk),
        .rst     (rst),
        .src_lvl ({cap_pin, cap_ctl}),
        .fire    (fire)
    );

    assign req.fire = fire;
    assign req.src  = pick_source(in_lock);

    pcap_snap #(.W(PAT_W)) i_snap (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .line_win (hist_q),
        .ref_win  (ref_window),
        .snap_q   (snap)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign lane[g] = snap[PAT_W-1-g*BYTE_W -: BYTE_W];
    end

    assign rd_byte = lane[byte_sel];

endmodule

// File: rtl/pcap_checker.sv
module pcap_checker #(
    parameter int PAT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_bit,
    input logic             in_lock,
    input logic [PAT_W-1:0] ref_window,
    input logic             cap_ctl,
    input logic             cap_pin,
    input logic [PAT_W-1:0] snap,
    input logic [PAT_W-1:0] hist
);

    logic ctl_d, pin_d;
    logic any_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_d <= 1'b0;
            pin_d <= 1'b0;
        end else begin
            ctl_d <= cap_ctl;
            pin_d <= cap_pin;
        end
    end

    assign any_rise = (cap_ctl && !ctl_d) || (cap_pin && !pin_d);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (snap == '0 && hist == '0));

    a_r2_shift_in: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (hist[0] == $past(rx_bit)));

    a_r3_line_capture: assert property (@(posedge clk) disable iff (rst)
        (any_rise && !in_lock) |=> (snap == $past(hist)));

    a_r4_ref_capture: assert property (@(posedge clk) disable iff (rst)
        (any_rise && in_lock) |=> (snap == $past(ref_window)));

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !any_rise |=> $stable(snap));

endmodule

bind rx_pattern_capture pcap_checker #(.PAT_W(PAT_W)) i_pcap_checker (
    .clk        (clk),
    .rst        (rst),
    .rx_bit     (rx_bit),
    .in_lock    (in_lock),
    .ref_window (ref_window),
    .cap_ctl    (cap_ctl),
    .cap_pin    (cap_pin),
    .snap       (snap),
    .hist       (hist_q)
);

// File: tb/test_rx_pattern_capture.sv
module test_rx_pattern_capture;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_bit = 1'b0;
    logic        in_lock = 1'b0;
    logic [31:0] ref_window = '0;
    logic        cap_ctl = 1'b0;
    logic        cap_pin = 1'b0;
    logic [1:0]  byte_sel = '0;
    logic [31:0] snap;
    logic [7:0]  rd_byte;

    always #5 clk = ~clk;

    rx_pattern_capture i_rx_pattern_capture (
        .clk        (clk),
        .rst        (rst),
        .rx_bit     (rx_bit),
        .in_lock    (in_lock),
        .ref_window (ref_window),
        .cap_ctl    (cap_ctl),
        .cap_pin    (cap_pin),
        .byte_sel   (byte_sel),
        .snap       (snap),
        .rd_byte    (rd_byte)
    );

    int    total = 0;
    int    bad   = 0;
    string tag   = "R1";

    // behavioural reference: bit queue for history, plain flags for edges
    bit    m_q[$];
    logic [31:0] m_snap = '0;
    bit    m_ctl_d = 0, m_pin_d = 0;

    function automatic logic [31:0] q_window();
        logic [31:0] w = '0;
        int n = m_q.size();
        for (int i = 0; i < 32; i++) begin
            if (i < n) w[i] = m_q[n-1-i];
        end
        return w;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_q.delete();
            m_snap  = '0;
            m_ctl_d = 0;
            m_pin_d = 0;
        end else begin
            if ((cap_ctl && !m_ctl_d) || (cap_pin && !m_pin_d))
                m_snap = in_lock ? ref_window : q_window();
            m_q.push_back(rx_bit);
            if (m_q.size() > 32) void'(m_q.pop_front());
            m_ctl_d = cap_ctl;
            m_pin_d = cap_pin;
        end
    end

    task automatic chk32(input string t, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic chk8(input string t, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", t, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_byte(input logic [31:0] w, input logic [1:0] s);
        return w[8*(3-int'(s)) +: 8];
    endfunction

    // one cycle: compare at the falling edge, then drive the next inputs
    task automatic cyc(input logic b, input logic lk, input logic c, input logic p,
                       input logic [31:0] rw);
        @(negedge clk);
        chk32(tag, snap, m_snap);
        chk8("R8", rd_byte, ref_byte(m_snap, byte_sel));
        rx_bit     = b;
        in_lock    = lk;
        cap_ctl    = c;
        cap_pin    = p;
        ref_window = rw;
        byte_sel   = byte_sel + 2'd1;
    endtask

    initial begin
        logic [31:0] k;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        tag = "R1";
        chk32("R1", snap, 32'h0);
        chk8("R1", rd_byte, 8'h00);

        // R2: known word first-to-last, then capture while unlocked
        tag = "R2";
        k = 32'hA5C3_0F96;
        for (int i = 31; i >= 0; i--) cyc(k[i], 1'b0, 1'b0, 1'b0, '0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, '0);
        @(negedge clk);
        chk32("R2", snap, k);
        for (int s = 0; s < 4; s++) begin
            byte_sel = 2'(s);
            #1;
            chk8("R8", rd_byte, ref_byte(k, 2'(s)));
        end
        cyc(1'b1, 1'b0, 1'b0, 1'b0, '0);

        // R3: unlocked captures with random line data
        tag = "R3";
        for (int i = 0; i < 60; i++)
            cyc(1'($urandom), 1'b0, (i % 7 == 3), 1'b0, $urandom);

        // R6: control held high, no repeat capture
        tag = "R6";
        for (int i = 0; i < 20; i++)
            cyc(1'($urandom), 1'b0, (i >= 2 && i < 15), (i >= 4 && i < 12), $urandom);

        // R5: pin pulses
        tag = "R5";
        for (int i = 0; i < 40; i++)
            cyc(1'($urandom), 1'b0, 1'b0, (i % 5 == 1), $urandom);

        // R4: locked, reference window changes every cycle, line noisy
        tag = "R4";
        for (int i = 0; i < 50; i++)
            cyc(1'($urandom), 1'b1, (i % 6 == 2), (i % 11 == 7), $urandom);

        // R7: simultaneous rises and rise while the other is held
        tag = "R7";
        for (int i = 0; i < 30; i++)
            cyc(1'($urandom), (i >= 15), (i % 10 == 3), (i % 10 >= 3 && i % 10 <= 6), $urandom);
        for (int i = 0; i < 10; i++)
            cyc(1'($urandom), 1'b0, (i >= 2), (i >= 5 && i < 8), $urandom);

        tag = "R6";
        for (int i = 0; i < 6; i++) cyc(1'($urandom), 1'b0, 1'b0, 1'b0, $urandom);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule